// File: doc/BRIEF.md
# Quiz Round First-Press Arbiter with Answer Countdown

This block runs one round of a four-contestant quiz. A host switch clears the block while it is low and arms a round while it is high. Each contestant has one active-low button. The block synchronizes the buttons to the system clock. It watches the combined "all idle" level of the buttons, which is the AND of the four active-low inputs. The first time that level falls, the block takes one snapshot of the buttons and locks. Any press after that cannot change the result until the host clears the block.

The snapshot becomes a one-hot lamp code for the winner. A simultaneous press gives an all-ones tie code. Locking also starts a two-digit BCD answer countdown from 99. The countdown steps once per tick. A built-in prescaler makes one tick every 2^TICK_LOG2 clock cycles; the default is 2^20. When the countdown reaches 00 it stops there and raises the buzzer flag. Debouncing, display decoding and tone generation belong outside this block.

Top module: `quiz_buzzer_top`

## Requirements
- R1: Buttons are active low and idle high. A press applied before rising edge k shows on the winner output after rising edge k+2, because of two synchronizer stages and one lock register.
- R2: While the host switch is low, the next rising edge gives winner 0000, tens 9, units 9 and buzzer 0. The button synchronizers, the lock and the prescaler are cleared as well.
- R3: Once locked, further presses or releases have no effect on the winner code or on the countdown until the host clears the block.
- R4: While locked, the winner code holds the same value on every cycle.
- R5: Button bit 0 alone gives winner 0001, bit 1 gives 0010, bit 2 gives 0100 and bit 3 gives 1000. Winner 0000 means no lock.
- R6: While armed but not locked, the digits stay at tens 9 and units 9 and the buzzer stays low.
- R7: While locked, each tick decrements the units digit. A units digit of 0 reloads to 9 and decrements the tens digit. Both digits stay in the range 0 to 9.
- R8: At tens 0 and units 0 the countdown stops, and the buzzer output is 1. The buzzer stays 1 until the host clears the block.
- R9: The prescaler restarts when the host clears the block. The first tick takes effect on the 2^TICK_LOG2-th rising edge after arming, and each later tick follows 2^TICK_LOG2 edges after the one before.
- R10: If two or more buttons go low in the same sampled cycle, the block still locks. The winner code is then 1111 and the countdown runs as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| host_arm_i | input | 1 | Host switch: low clears the block, high arms the round |
| btn_n_i | input | 4 | Contestant buttons, active low |
| winner_o | output | 4 | One-hot winner lamps; 1111 on a tie, 0000 when not locked |
| tens_o | output | 4 | Countdown tens digit in BCD |
| units_o | output | 4 | Countdown units digit in BCD |
| buzzer_o | output | 1 | High once the countdown has expired |

## Verification
The first tests press each button alone, which tells the four one-hot codes apart. After each lock, every button is pressed and then all are released, to show that later activity leaves both the code and the countdown alone. A two-button press in one cycle separates the tie code from any single winner and shows the countdown still runs. The digits are compared on every cycle across a ones-to-tens reload, from the first tick after arming, and through expiry to a held 00 with the buzzer. Each of these is checked against a model that counts clock edges in the bench.

// File: rtl/quiz_pkg.sv
package quiz_pkg;
    localparam int PLAYERS = 4;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

    // Converts an active-low snapshot to the lamp code.
    // Exactly one low bit selects that lamp; any other pattern gives all ones.
    function automatic logic [PLAYERS-1:0] lamp_code(input logic [PLAYERS-1:0] snap_n);
        logic [PLAYERS-1:0] code;
        int lows;
        code = '0;
        lows = 0;
        for (int i = 0; i < PLAYERS; i++) begin
            if (!snap_n[i]) begin
                code[i] = 1'b1;
                lows++;
            end
        end
        return (lows == 1) ? code : '1;
    endfunction
endpackage

// File: rtl/quiz_sync.sv
module quiz_sync #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         arm_i,
    input  logic [W-1:0] async_n_i,
    output logic [W-1:0] sync_n_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!arm_i) begin
            s_d.stage1 = '1;
            s_d.stage2 = '1;
        end else begin
            s_d.stage1 = async_n_i;
            s_d.stage2 = s_q.stage1;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign sync_n_o = s_q.stage2;
endmodule

// File: rtl/quiz_tick.sv
module quiz_tick #(
    parameter int TICK_LOG2 = 20
) (
    input  logic clk_i,
    input  logic arm_i,
    output logic tick_o
);
    logic [TICK_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = arm_i ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign tick_o = arm_i && (&cnt_q);
endmodule

// File: rtl/quiz_capture.sv
module quiz_capture
    import quiz_pkg::*;
(
    input  logic               clk_i,
    input  logic               arm_i,
    input  logic [PLAYERS-1:0] btn_sync_n_i,
    output logic               locked_o,
    output logic [PLAYERS-1:0] winner_o
);
    typedef struct packed {
        logic               idle_prev;
        logic               locked;
        logic [PLAYERS-1:0] snap_n;
    } cap_t;

    cap_t c_d, c_q;
    logic idle_now;
    logic first_fall;

    assign idle_now   = &btn_sync_n_i;
    assign first_fall = c_q.idle_prev && !idle_now && !c_q.locked;

    always_comb begin
        c_d = c_q;
        if (!arm_i) begin
            c_d.idle_prev = 1'b1;
            c_d.locked    = 1'b0;
            c_d.snap_n    = '1;
        end else begin
            c_d.idle_prev = idle_now;
            if (first_fall) begin
                c_d.locked = 1'b1;
                c_d.snap_n = btn_sync_n_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        c_q <= c_d;
    end

    assign locked_o = c_q.locked;
    assign winner_o = c_q.locked ? lamp_code(c_q.snap_n) : '0;
endmodule

// File: rtl/quiz_countdown.sv
module quiz_countdown
    import quiz_pkg::*;
(
    input  logic               clk_i,
    input  logic               arm_i,
    input  logic               locked_i,
    input  logic               tick_i,
    output logic [DIGIT_W-1:0] tens_o,
    output logic [DIGIT_W-1:0] units_o,
    output logic               expired_o
);
    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } cd_t;

    cd_t d_d, d_q;
    logic at_zero;

    assign at_zero = (d_q.tens == '0) && (d_q.units == '0);

    always_comb begin
        d_d = d_q;
        if (!arm_i || !locked_i) begin
            d_d.tens  = DIGIT_MAX;
            d_d.units = DIGIT_MAX;
        end else if (tick_i && !at_zero) begin
            if (d_q.units == '0) begin
                d_d.units = DIGIT_MAX;
                d_d.tens  = d_q.tens - 1'b1;
            end else begin
                d_d.units = d_q.units - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        d_q <= d_d;
    end

    assign tens_o    = d_q.tens;
    assign units_o   = d_q.units;
    assign expired_o = locked_i && at_zero;
endmodule

// File: rtl/quiz_buzzer_top.sv
module quiz_buzzer_top
    import quiz_pkg::*;
#(
    parameter int TICK_LOG2 = 20
) (
    input  logic               clk_i,
    input  logic               host_arm_i,
    input  logic [PLAYERS-1:0] btn_n_i,
    output logic [PLAYERS-1:0] winner_o,
    output logic [DIGIT_W-1:0] tens_o,
    output logic [DIGIT_W-1:0] units_o,
    output logic               buzzer_o
);
    logic [PLAYERS-1:0] btn_sync_n;
    logic               locked;
    logic               tick;

    quiz_sync #(.W(PLAYERS)) u_sync (
        .clk_i     (clk_i),
        .arm_i     (host_arm_i),
        .async_n_i (btn_n_i),
        .sync_n_o  (btn_sync_n)
    );

    quiz_tick #(.TICK_LOG2(TICK_LOG2)) u_tick (
        .clk_i  (clk_i),
        .arm_i  (host_arm_i),
        .tick_o (tick)
    );

    quiz_capture u_capture (
        .clk_i        (clk_i),
        .arm_i        (host_arm_i),
        .btn_sync_n_i (btn_sync_n),
        .locked_o     (locked),
        .winner_o     (winner_o)
    );

    quiz_countdown u_countdown (
        .clk_i     (clk_i),
        .arm_i     (host_arm_i),
        .locked_i  (locked),
        .tick_i    (tick),
        .tens_o    (tens_o),
        .units_o   (units_o),
        .expired_o (buzzer_o)
    );
endmodule

// File: rtl/quiz_buzzer_chk.sv
module quiz_buzzer_chk (
    input logic       clk_i,
    input logic       host_arm_i,
    input logic [3:0] winner_o,
    input logic [3:0] tens_o,
    input logic [3:0] units_o,
    input logic       buzzer_o
);
    p_clear_r2: assert property (@(posedge clk_i)
        !host_arm_i |=> (winner_o == 4'h0 && tens_o == 4'd9 && units_o == 4'd9 && !buzzer_o));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        (winner_o != 4'h0) |=> $stable(winner_o));

    p_code_r5: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        ($countones(winner_o) <= 1) || (winner_o == 4'hF));

    p_idle99_r6: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        (winner_o == 4'h0) |-> (tens_o == 4'd9 && units_o == 4'd9 && !buzzer_o));

    p_bcd_r7: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        (tens_o <= 4'd9) && (units_o <= 4'd9));

    p_zero_r8: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        buzzer_o |-> (tens_o == 4'd0 && units_o == 4'd0 && winner_o != 4'h0));

    p_stop_r8: assert property (@(posedge clk_i) disable iff (!host_arm_i)
        buzzer_o |=> (buzzer_o && $stable(tens_o) && $stable(units_o)));
endmodule

bind quiz_buzzer_top quiz_buzzer_chk chk_i (
    .clk_i      (clk_i),
    .host_arm_i (host_arm_i),
    .winner_o   (winner_o),
    .tens_o     (tens_o),
    .units_o    (units_o),
    .buzzer_o   (buzzer_o)
);

// File: tb/quiz_buzzer_top_tb_top.sv
`timescale 1ns/1ps
module quiz_buzzer_top_tb_top;
    localparam int TLOG = 3;
    localparam int DIV  = 1 << TLOG;

    logic       clk = 1'b0;
    logic       host_arm = 1'b0;
    logic [3:0] btn_n = 4'hF;
    logic [3:0] winner, tens, units;
    logic       buzzer;

    int tests = 0;
    int fails = 0;
    int e_cnt = 0;
    int press_e = -1;
    logic [3:0] exp_win = 4'h0;
    bit done = 0;

    typedef struct {
        logic [3:0] w;
        logic [3:0] t;
        logic [3:0] u;
        logic       b;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    quiz_buzzer_top #(.TICK_LOG2(TLOG)) dut_i (
        .clk_i      (clk),
        .host_arm_i (host_arm),
        .btn_n_i    (btn_n),
        .winner_o   (winner),
        .tens_o     (tens),
        .units_o    (units),
        .buzzer_o   (buzzer)
    );

    // Edges seen since arming (0 while the host holds the block clear)
    always @(posedge clk) e_cnt <= host_arm ? e_cnt + 1 : 0;

    function automatic int ticks_done(input int e, input int pe);
        int n = 0;
        for (int j = pe + 3; j < e; j++) if ((j % DIV) == DIV - 1) n++;
        return (n > 99) ? 99 : n;
    endfunction

    function automatic logic [3:0] model_code(input logic [3:0] p);
        int lows = 0;
        logic [3:0] c = 4'h0;
        for (int i = 0; i < 4; i++) if (!p[i]) begin lows++; c[i] = 1'b1; end
        return (lows == 1) ? c : 4'hF;
    endfunction

    // Driver side: compute expectation right after an edge, push it
    task automatic check(input string tag);
        item_t it;
        int n;
        bit lk;
        @(posedge clk);
        #1;
        lk = host_arm && press_e >= 0 && e_cnt >= press_e + 3;
        n  = lk ? ticks_done(e_cnt, press_e) : 0;
        it.w = lk ? exp_win : 4'h0;
        it.t = 4'((99 - n) / 10);
        it.u = 4'((99 - n) % 10);
        it.b = lk && (n == 99);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor side: pop and compare away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            tests++;
            if (winner !== it.w || tens !== it.t || units !== it.u || buzzer !== it.b) begin
                fails++;
                $display("FAIL %s: got w=%b t=%0d u=%0d b=%b, expected w=%b t=%0d u=%0d b=%b",
                         it.tag, winner, tens, units, buzzer, it.w, it.t, it.u, it.b);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_round();
        @(negedge clk);
        host_arm = 1'b0;
        btn_n    = 4'hF;
        press_e  = -1;
        exp_win  = 4'h0;
        @(negedge clk);
    endtask

    task automatic arm_round();
        @(negedge clk);
        host_arm = 1'b1;
    endtask

    task automatic press(input logic [3:0] p);
        @(negedge clk);
        btn_n = p;
        if (press_e < 0 && p != 4'hF) begin
            press_e = e_cnt;
            exp_win = model_code(p);
        end
    endtask

    initial begin
        wait_cyc(3);
        check("R2 reset state");
        arm_round();
        wait_cyc(20);
        check("R6 armed, no press, holds 99");

        for (int i = 0; i < 4; i++) begin
            clear_round();
            arm_round();
            wait_cyc(5);
            press(~(4'b0001 << i));
            for (int k = 0; k < 4; k++) check("R1 latency / R5 single winner code");
            press(4'h0);
            wait_cyc(3);
            check("R3 later presses ignored");
            press(4'hF);
            wait_cyc(3);
            check("R4 code held after release");
        end

        // Countdown across a units reload, compared every cycle
        for (int k = 0; k < 120; k++) check("R7 decrement and reload");
        wait_cyc(820);
        check("R8 expiry at 00 with buzzer");
        press(4'b1100);
        wait_cyc(20);
        check("R8 stays at 00 / R3 presses ignored");

        // Tie
        clear_round();
        check("R2 clear after expiry");
        arm_round();
        wait_cyc(4);
        press(4'b1010);
        wait_cyc(4);
        check("R10 tie gives 1111");
        wait_cyc(40);
        check("R10 tie countdown runs");

        // Prescaler phase from arming, press on the first armed cycle
        clear_round();
        arm_round();
        press(4'b0111);
        for (int k = 0; k < 20; k++) check("R9 tick spacing from arm");

        // Clear mid-round
        @(negedge clk);
        host_arm = 1'b0;
        press_e  = -1;
        check("R2 clear mid-round");

        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got run still busy, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule